// File: doc/BRIEF.md
# I2C Serial EEPROM Target with Write Protection

This block is an I2C target that exposes a 256-byte store, arranged as 16 pages of 16 bytes. It samples the bus lines on the system clock, recognises START and STOP conditions, and answers its memory device address when the three strap inputs match. After a word address, data bytes are collected in a 16-byte page buffer. The buffer is committed to the array when STOP arrives. Reads can start from the current pointer, from an address just written with a repeated START in between, or run on as a sequential burst.

Writes pass through two gates. A hardware pin blocks every commit. A software flag blocks commits to the lower half of the store. The software flag has a reversible form and a permanent form, and both are driven by dedicated protection commands on the bus. After a commit, the target models the programming time by refusing its address for a fixed number of clock cycles. A host can therefore poll for completion by acknowledge.

The bus side is open-drain and uses plain pins only: `sda_oe_o` high pulls SDA low. No stream handshake is present, because the pace of the transfer is set entirely by SCL.

Top module: `eep_i2c_target`

## Requirements
- R1: A device byte with upper nibble 1010 and bits [3:1] equal to `strap_i` is acknowledged. Any other byte, except a protection command, gets NACK, and SDA stays released until the next START. SDA is released in the cycle after every START.
- R2: In a write, the byte after the device byte loads the address pointer. A single data byte is stored at that address when STOP arrives.
- R3: Data bytes fill a 16-entry page buffer. The low 4 pointer bits wrap within the page, so a later byte to the same slot replaces the earlier one. The whole page commits at STOP.
- R4: A read returns the byte at the pointer and then increments all 8 pointer bits, wrapping from 0xFF to 0x00. A master ACK requests the next byte. A NACK ends the read. A repeated START after the word address gives a random read.
- R5: While `wp_i` is high at STOP, no location changes. The data bytes are still acknowledged.
- R6: While the software flag (reversible or permanent) is set, commits to 0x00-0x7F are dropped. Commits to 0x80-0xFF go through.
- R7: A protection command is the device byte {0110, op[2:0], 0}. It ignores the straps. op 001 sets the reversible flag, op 011 clears it, and op 100 sets the permanent flag. Other op values get NACK. The command acts at the following STOP.
- R8: Once the permanent flag is set, it never clears until `rst_n`. Every protection command is then answered with NACK.
- R9: A STOP that ends a write with at least one data byte starts a programming interval of PROG_CYCLES clocks. During that interval device bytes get NACK, and after it they are acknowledged again.
- R10: After reset, every byte reads 0xFF, the pointer is 0, both flags are clear, and SDA is released.
- R11: Operation is independent of the SCL rate, as long as each SCL phase lasts at least 6 clock cycles and SDA changes only while SCL is low.
- R12: The target changes `sda_oe_o` to drive SDA only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 3 | Address strap bits compared with device byte bits [3:1] |
| wp_i | input | 1 | Hardware write protect, blocks all commits |
| rst_n | - | - | - |

## Verification
The checker watches, on every cycle, that SDA is only grabbed while SCL is low and is let go after START, that no commit happens while the pin protect is high or while the software flag guards the lower half, that each commit opens a programming window with no second commit inside it, and that the permanent flag never falls. Page-wrap ordering, pointer wrap across the whole store, straps that do not match, acknowledge polling that ends when programming finishes, the NACK of protection commands under the permanent flag, and read-back after mixed protected and unprotected writes at two bus rates can only be shown by the bench scenarios, which compare against a reference model of the store.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ACK, ST_WA, ST_WD, ST_RD, ST_RACK, ST_CMD
  } ph_t;

  localparam logic [3:0] KIND_MEM  = 4'b1010;
  localparam logic [3:0] KIND_PROT = 4'b0110;

  localparam logic [2:0] OP_SET_REV  = 3'b001;
  localparam logic [2:0] OP_CLR_REV  = 3'b011;
  localparam logic [2:0] OP_SET_PERM = 3'b100;

endpackage

// File: rtl/eep_line_cond.sv
module eep_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edge while clock stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter  int PAGE_W = 4,
  localparam int PB     = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] idx,
  input  logic [7:0]        din,
  output logic [PB*8-1:0]   data_o,
  output logic [PB-1:0]     mask_o
);
  for (genvar s = 0; s < PB; s++) begin : g_slot
    logic [7:0] slot_q;
    logic       vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr) begin
        vld_q  <= 1'b0;
      end else if (wr && idx == PAGE_W'(s)) begin
        slot_q <= din;
        vld_q  <= 1'b1;
      end
    end
    assign data_o[s*8 +: 8] = slot_q;
    assign mask_o[s]        = vld_q;
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter  int ADDR_W  = 8,
  parameter  int PAGE_W  = 4,
  localparam int PB      = 1 << PAGE_W,
  localparam int PAGE_IW = ADDR_W - PAGE_W,
  localparam int NPAGES  = 1 << PAGE_IW,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  input  logic               we,
  input  logic [PAGE_IW-1:0] wr_page,
  input  logic [PB*8-1:0]    wr_data,
  input  logic [PB-1:0]      wr_mask
);
  logic [DEPTH*8-1:0] cells;

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    logic hit;
    assign hit = we && (wr_page == PAGE_IW'(p));
    for (genvar b = 0; b < PB; b++) begin : g_byte
      logic [7:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cell_q <= 8'hFF;
        else if (hit && wr_mask[b])  cell_q <= wr_data[b*8 +: 8];
      end
      assign cells[(p*PB+b)*8 +: 8] = cell_q;
    end
  end

  assign rd_data = cells[rd_addr*8 +: 8];
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int PB      = 1 << PAGE_W;
  localparam int PAGE_IW = ADDR_W - PAGE_W;
  localparam int BUSY_W  = $clog2(PROG_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ph_t               state_q, after_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              mack_q, wrote_q, cmd_pend_q, rev_wp_q, perm_wp_q;
  logic [2:0]        cmd_q;
  logic [BUSY_W-1:0] busy_q;

  logic busy_nz, swp, commit, buf_wr, load_rd, mem_hit, cmd_hit, op_ok, byte_done;
  logic [7:0]         rd_data;
  logic [PB*8-1:0]    buf_data;
  logic [PB-1:0]      buf_mask, mask_eff;
  logic [PAGE_IW-1:0] arr_page;
  logic               arr_we, wr_upper;

  assign busy_nz   = busy_q != '0;
  assign swp       = rev_wp_q | perm_wp_q;
  assign byte_done = scl_fall && bitcnt_q == 4'd8;
  assign op_ok     = shreg_q[3:1] == OP_SET_REV || shreg_q[3:1] == OP_CLR_REV ||
                     shreg_q[3:1] == OP_SET_PERM;
  assign mem_hit   = shreg_q[7:4] == KIND_MEM && shreg_q[3:1] == strap_i && !busy_nz;
  assign cmd_hit   = shreg_q[7:4] == KIND_PROT && !shreg_q[0] && op_ok &&
                     !perm_wp_q && !busy_nz;
  assign load_rd   = scl_fall && ((state_q == ST_ACK && after_q == ST_RD) ||
                                  (state_q == ST_RACK && mack_q));
  assign buf_wr    = state_q == ST_WD && byte_done;
  assign commit    = stop_det && wrote_q;

  // protection gating of the page commit
  assign arr_page = ptr_q[ADDR_W-1:PAGE_W];
  assign wr_upper = arr_page[PAGE_IW-1];
  assign mask_eff = (wp_i || (swp && !wr_upper)) ? '0 : buf_mask;
  assign arr_we   = commit && (|mask_eff);

  eep_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(start_det | stop_det), .wr(buf_wr),
    .idx(ptr_q[PAGE_W-1:0]), .din(shreg_q), .data_o(buf_data), .mask_o(buf_mask)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(ptr_q), .rd_data(rd_data),
    .we(arr_we), .wr_page(arr_page), .wr_data(buf_data), .wr_mask(mask_eff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (commit)  busy_q <= BUSY_W'(PROG_CYCLES);
    else if (busy_nz) busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  after_q <= ST_IDLE;  bitcnt_q <= '0;  shreg_q <= '0;
      ptr_q <= '0;  mack_q <= 1'b0;  wrote_q <= 1'b0;  cmd_pend_q <= 1'b0;
      cmd_q <= '0;  rev_wp_q <= 1'b0;  perm_wp_q <= 1'b0;  sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_DEV;  bitcnt_q <= '0;  sda_oe_o <= 1'b0;
      wrote_q <= 1'b0;    cmd_pend_q <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;  sda_oe_o <= 1'b0;  wrote_q <= 1'b0;  cmd_pend_q <= 1'b0;
      if (cmd_pend_q) begin
        case (cmd_q)
          OP_SET_REV:  rev_wp_q  <= 1'b1;
          OP_CLR_REV:  rev_wp_q  <= 1'b0;
          OP_SET_PERM: perm_wp_q <= 1'b1;
          default: ;
        endcase
      end
    end else if (load_rd) begin
      shreg_q  <= rd_data;
      sda_oe_o <= ~rd_data[7];
      bitcnt_q <= 4'd1;
      ptr_q    <= ptr_q + 1'b1;
      state_q  <= ST_RD;
    end else begin
      case (state_q)
        ST_DEV, ST_WA, ST_WD: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            bitcnt_q <= '0;
            sda_oe_o <= 1'b1;
            state_q  <= ST_ACK;
            after_q  <= ST_WD;
            if (state_q == ST_DEV) begin
              if (mem_hit) begin
                after_q <= shreg_q[0] ? ST_RD : ST_WA;
              end else if (cmd_hit) begin
                after_q <= ST_CMD;
                cmd_q   <= shreg_q[3:1];
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_IDLE;
              end
            end else if (state_q == ST_WA) begin
              ptr_q <= ADDR_W'(shreg_q);
            end else begin
              ptr_q   <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
              wrote_q <= 1'b1;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          sda_oe_o <= 1'b0;
          if (after_q == ST_CMD) cmd_pend_q <= 1'b1;
          state_q <= after_q;
        end
        ST_RD: if (scl_fall) begin
          if (bitcnt_q == 4'd8) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_RACK;
          end else begin
            shreg_q  <= {shreg_q[6:0], 1'b0};
            sda_oe_o <= ~shreg_q[6];
            bitcnt_q <= bitcnt_q + 1'b1;
          end
        end
        ST_RACK: begin
          if (scl_rise)      mack_q  <= ~sda_s;
          else if (scl_fall) state_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_i2c_target_chk.sv
module eep_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic start_det,
  input logic wp_i,
  input logic arr_we,
  input logic swp,
  input logic wr_upper,
  input logic busy_nz,
  input logic perm_wp
);
  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_release_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_pin_blocks_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !wp_i);

  assert_lower_half_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && swp) |-> wr_upper);

  assert_commit_opens_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> busy_nz);

  assert_no_commit_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_nz |-> !arr_we);

  assert_perm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(perm_wp));
endmodule

bind eep_i2c_target eep_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o), .start_det(start_det),
  .wp_i(wp_i), .arr_we(arr_we), .swp(swp), .wr_upper(wr_upper),
  .busy_nz(busy_nz), .perm_wp(perm_wp_q)
);

// File: tb/tb_eep_i2c_target.sv
module tb_eep_i2c_target;
  localparam int PROG = 600;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  eep_i2c_target #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  int total = 0, bad = 0, tq = 10;
  bit finished = 1'b0;
  logic [7:0] model [256];
  logic [7:0] exp_ptr;
  bit m_rev, m_perm;
  logic [7:0] wbuf [20];

  task automatic chk_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(tq); scl_m = 1'b1; tick(tq);
    sda_m = 1'b0; tick(tq); scl_m = 1'b0; tick(tq);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(tq); scl_m = 1'b1; tick(tq); sda_m = 1'b1; tick(tq);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(tq); scl_m = 1'b1; tick(2*tq); scl_m = 1'b0; tick(tq);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(tq); scl_m = 1'b1; tick(tq);
    b = sda_line; tick(tq); scl_m = 1'b0; tick(tq);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!ack);
  endtask

  function automatic logic [7:0] dev(bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  function automatic bit guarded(logic [7:0] a);
    return wp || ((m_rev || m_perm) && !a[7]);
  endfunction

  task automatic fill(int n);
    for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
  endtask

  task automatic do_write(logic [7:0] a, int n);
    bit ack;
    int polls;
    logic [7:0] ad;
    i2c_start;
    send_byte(dev(1'b0), ack); chk_eq("R1", "device ack", ack, 1);
    send_byte(a, ack);         chk_eq("R2", "word addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk_eq(wp ? "R5" : "R3", "data ack", ack, 1);
    end
    i2c_stop;
    for (int i = 0; i < n; i++) begin
      ad = {a[7:4], 4'(a[3:0] + i)};
      if (!guarded(ad)) model[ad] = wbuf[i];
    end
    exp_ptr = {a[7:4], 4'(a[3:0] + n)};
    i2c_start; send_byte(dev(1'b0), ack); i2c_stop;
    chk_eq("R9", "address during programming", ack, 0);
    polls = 0;
    do begin
      i2c_start; send_byte(dev(1'b0), ack); i2c_stop; polls++;
    end while (!ack && polls < 50);
    chk_eq("R9", "ack once programming ends", ack, 1);
  endtask

  task automatic do_read(logic [7:0] a, int n, string req);
    bit ack;
    logic [7:0] v;
    i2c_start;
    send_byte(dev(1'b0), ack); chk_eq("R1", "device ack", ack, 1);
    send_byte(a, ack);         chk_eq("R2", "word addr ack", ack, 1);
    i2c_start;
    send_byte(dev(1'b1), ack); chk_eq("R4", "read device ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      chk_eq(req, "read data", v, model[8'(a + i)]);
    end
    i2c_stop;
    exp_ptr = 8'(a + n);
  endtask

  task automatic cur_read(int n, string req);
    bit ack;
    logic [7:0] v;
    i2c_start;
    send_byte(dev(1'b1), ack); chk_eq(req, "current read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      chk_eq(req, "current read data", v, model[8'(exp_ptr + i)]);
    end
    i2c_stop;
    exp_ptr = 8'(exp_ptr + n);
  endtask

  task automatic prot_cmd(logic [2:0] op, bit exp_ack, string req);
    bit ack;
    i2c_start; send_byte({4'b0110, op, 1'b0}, ack); i2c_stop;
    chk_eq(req, "protection command ack", ack, exp_ack);
    if (ack) begin
      if (op == 3'b001) m_rev = 1'b1;
      if (op == 3'b011) m_rev = 1'b0;
      if (op == 3'b100) m_perm = 1'b1;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    exp_ptr = 8'h00; m_rev = 1'b0; m_perm = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);

    chk_eq("R10", "sda released after reset", sda_oe, 0);
    cur_read(2, "R10");

    // straps that do not match: nothing acked, nothing stored
    i2c_start;
    send_byte({4'b1010, 3'b011, 1'b0}, ack); chk_eq("R1", "foreign strap nack", ack, 0);
    send_byte(8'h40, ack);                   chk_eq("R1", "ignored byte", ack, 0);
    send_byte(8'h5A, ack);                   chk_eq("R1", "ignored byte", ack, 0);
    i2c_stop;
    do_read(8'h40, 1, "R1");

    wbuf[0] = 8'h3C; do_write(8'h41, 1); do_read(8'h41, 1, "R2");
    wbuf[0] = 8'hA7; do_write(8'h55, 1); cur_read(1, "R4");

    fill(16); do_write(8'h35, 16); do_read(8'h30, 16, "R3");
    fill(18); do_write(8'h6E, 18); do_read(8'h60, 16, "R3");

    fill(16); do_write(8'hF0, 16); do_read(8'hFC, 8, "R4");

    tq = 6; fill(5); do_write(8'h83, 5); do_read(8'h80, 8, "R11"); tq = 10;

    wp = 1'b1; fill(4); do_write(8'h90, 4); fill(2); do_write(8'h08, 2); wp = 1'b0;
    do_read(8'h90, 4, "R5"); do_read(8'h08, 2, "R5");

    prot_cmd(3'b001, 1'b1, "R7");
    fill(4); do_write(8'h10, 4); do_read(8'h10, 4, "R6");
    fill(4); do_write(8'hA0, 4); do_read(8'hA0, 4, "R6");
    prot_cmd(3'b111, 1'b0, "R7");
    prot_cmd(3'b011, 1'b1, "R7");
    fill(4); do_write(8'h10, 4); do_read(8'h10, 4, "R7");

    for (int k = 0; k < 6; k++) begin
      logic [7:0] a;
      int n;
      if ($urandom % 4 == 0) prot_cmd(($urandom % 2) ? 3'b001 : 3'b011, 1'b1, "R7");
      wp = ($urandom % 4) == 0;
      a = 8'($urandom);
      n = 1 + int'($urandom % 12);
      fill(n); do_write(a, n); wp = 1'b0;
      do_read({a[7:4], 4'h0}, 6, "R4");
      cur_read(2, "R4");
    end

    prot_cmd(3'b100, 1'b1, "R8");
    prot_cmd(3'b011, 1'b0, "R8");
    prot_cmd(3'b001, 1'b0, "R8");
    fill(4); do_write(8'h20, 4); do_read(8'h20, 4, "R8");
    fill(4); do_write(8'hC4, 4); do_read(8'hC4, 4, "R8");

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule